// File: doc/BRIEF.md
# Edge-Interval Baud Rate Detector

This block watches a raw serial receive line and measures the spacing between like transitions: one counter times the gap from each rising edge to the next rising edge, and a second counter does the same for falling edges. Each measured gap is compared against a programmable lower and upper limit. For every pair of like transitions the block emits a one-cycle pass strobe or a one-cycle fail strobe for that edge type.

The interval counters do not wrap to zero. After reaching 29 the next tick loads 10, so the counter cycles through 10..29 once it has passed 29. Gaps of 20, 40, 60 and so on ticks therefore all read as 20, and gaps of 30, 50 and so on all read as 10. The limits are compared against this folded value. A tick is one clock period, or two clock periods when the halving select is set. With a 20 MHz clock and no halving, a limit of 20 matches the nominal bit spacing of a 1 Mbit/s stream.

The serial input first passes through a two-stage synchroniser. Software-side logic writes the two 6-bit limits through a one-cycle write strobe with a select bit. Deciding on baud lock from a run of passes is left to the surrounding logic.

Top module: `baud_interval_check`

## Requirements
- R1: Reset clears all four strobes and both limits to 0. With both limits at 0 every measured pair fails.
- R2: A change on `rxd_in` that is set up before clock edge A produces its pass or fail strobe as a register output updated on clock edge A+2.
- R3: The first rising edge and the first falling edge after reset only start their counters and produce no strobe.
- R4: A pair passes when lower ≤ measured ≤ upper. Both bounds are inclusive.
- R5: A pair whose measured value is below the lower limit fails.
- R6: A pair whose measured value is above the upper limit fails.
- R7: The measured value of a gap of N ticks is N for N ≤ 29. Beyond that the counter folds from 29 back to 10, so 40 ticks reads 20 and 30 ticks reads 10. The counter never holds a value above 29.
- R8: Rising and falling edges are timed by separate counters. A rising-edge result depends only on the gap between rising edges, and a falling-edge result depends only on the gap between falling edges.
- R9: With `half_rate` = 0 a tick is one clock. With `half_rate` = 1 a tick is two clocks, so an even gap of N clocks reads N/2.
- R10: A limit write stores `cfg_wdata[5:0]`. `cfg_sel` = 0 selects the lower limit and `cfg_sel` = 1 selects the upper limit. Bits 7 and 6 are ignored.
- R11: Each strobe lasts one cycle. The pass and fail strobes of one edge type are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd_in | input | 1 | Asynchronous serial receive line |
| half_rate | input | 1 | 1: one tick per two clocks; 0: one tick per clock |
| cfg_we | input | 1 | Limit write strobe |
| cfg_sel | input | 1 | 0 = lower limit, 1 = upper limit |
| cfg_wdata | input | 8 | Write data; bits 5:0 used |
| rise_pass | output | 1 | Rising-edge pair within limits |
| rise_fail | output | 1 | Rising-edge pair outside limits |
| fall_pass | output | 1 | Falling-edge pair within limits |
| fall_fail | output | 1 | Falling-edge pair outside limits |

## Verification
Square waves of period 20 are checked against a window around 20 and against windows that sit just above or just below it. Windows equal to the period on either side separate inclusive bounds from exclusive ones. Periods of 30 and 40 probe the fold, because a plain wrap or a saturating counter gives different readings there. A wave whose duty cycle changes from cycle to cycle gives rising intervals and falling intervals that differ, so the results show whether each counter is restarted only by its own edge type. Running the same 24-clock period with and without halving tells one-clock ticks from two-clock ticks. Further checks cover writes with the reserved bits set, a single edge after reset, and the exact strobe cycle.

// File: rtl/baud_interval_check.sv
module baud_interval_check #(
  parameter int LIM_W    = 6,
  parameter int CNT_W    = 5,
  parameter int WRAP_TOP = 29,
  parameter int WRAP_TO  = 10,
  parameter int SYNC_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_in,
  input  logic       half_rate,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic       rise_pass,
  output logic       rise_fail,
  output logic       fall_pass,
  output logic       fall_fail
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(WRAP_TOP);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(WRAP_TO);

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic              phase_q;
  logic [LIM_W-1:0]  lo_q, hi_q;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [1:0]        armed_q, pass_q, fail_q, hit;
  logic              rx_s, tick;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return (c == TOP) ? BASE : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], rxd_in};
      last_q  <= sync_q[SYNC_N-1];
      phase_q <= half_rate ? ~phase_q : 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) hi_q <= cfg_wdata[LIM_W-1:0];
      else         lo_q <= cfg_wdata[LIM_W-1:0];
    end

  assign rx_s   = sync_q[SYNC_N-1];
  assign tick   = ~half_rate | phase_q;
  assign hit[0] = rx_s & ~last_q;
  assign hit[1] = ~rx_s & last_q;

  for (genvar g = 0; g < 2; g++) begin : g_edge
    logic [CNT_W-1:0] meas;
    logic             ok;
    assign meas = tick ? step(cnt_q[g]) : cnt_q[g];
    assign ok   = ({{LIM_W{1'b0}}, meas} >= {{CNT_W{1'b0}}, lo_q}) &&
                  ({{LIM_W{1'b0}}, meas} <= {{CNT_W{1'b0}}, hi_q});

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[g]   <= '0;
        armed_q[g] <= 1'b0;
        pass_q[g]  <= 1'b0;
        fail_q[g]  <= 1'b0;
      end else if (hit[g]) begin
        cnt_q[g]   <= '0;
        armed_q[g] <= 1'b1;
        pass_q[g]  <= armed_q[g] & ok;
        fail_q[g]  <= armed_q[g] & ~ok;
      end else begin
        if (tick) cnt_q[g] <= step(cnt_q[g]);
        pass_q[g] <= 1'b0;
        fail_q[g] <= 1'b0;
      end
  end

  assign rise_pass = pass_q[0];
  assign rise_fail = fail_q[0];
  assign fall_pass = pass_q[1];
  assign fall_fail = fail_q[1];
endmodule

// File: rtl/baud_interval_check_sva.sv
module baud_interval_check_sva #(
  parameter int LIM_W    = 6,
  parameter int CNT_W    = 5,
  parameter int WRAP_TOP = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rise_pass,
  input logic                  rise_fail,
  input logic                  fall_pass,
  input logic                  fall_fail,
  input logic [LIM_W-1:0]      lo_q,
  input logic [LIM_W-1:0]      hi_q,
  input logic [1:0]            armed_q,
  input logic [1:0][CNT_W-1:0] cnt_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(rise_pass || rise_fail || fall_pass || fall_fail));

  assert_first_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pass || rise_fail) |-> $past(armed_q[0]));

  assert_first_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pass || fall_fail) |-> $past(armed_q[1]));

  assert_pass_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pass || fall_pass) |-> $past(lo_q) <= $past(hi_q));

  assert_fold_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] <= CNT_W'(WRAP_TOP)) && (cnt_q[1] <= CNT_W'(WRAP_TOP)));

  assert_rise_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pass || rise_fail) |=> !(rise_pass || rise_fail));

  assert_fall_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_pass || fall_fail) |=> !(fall_pass || fall_fail));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_pass && rise_fail) && !(fall_pass && fall_fail));
endmodule

bind baud_interval_check baud_interval_check_sva #(
  .LIM_W(LIM_W), .CNT_W(CNT_W), .WRAP_TOP(WRAP_TOP)
) u_sva (
  .clk(clk), .rst_n(rst_n),
  .rise_pass(rise_pass), .rise_fail(rise_fail),
  .fall_pass(fall_pass), .fall_fail(fall_fail),
  .lo_q(lo_q), .hi_q(hi_q), .armed_q(armed_q), .cnt_q(cnt_q)
);

// File: tb/tb_baud_interval_check.sv
module tb_baud_interval_check;
  logic clk = 1'b0, rst_n = 1'b0, rxd_in = 1'b0, half_rate = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic rise_pass, rise_fail, fall_pass, fall_fail;
  int rp, rf, fp, ff, tests, fails;
  bit done;

  always #5 clk = ~clk;

  baud_interval_check dut (
    .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .half_rate(half_rate),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rise_pass(rise_pass), .rise_fail(rise_fail),
    .fall_pass(fall_pass), .fall_fail(fall_fail));

  always @(negedge clk) begin
    if (rise_pass) rp++;
    if (rise_fail) rf++;
    if (fall_pass) fp++;
    if (fall_fail) ff++;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit half);
    @(negedge clk);
    rst_n = 1'b0; rxd_in = 1'b0; half_rate = half;
    repeat (3) @(negedge clk);
    rp = 0; rf = 0; fp = 0; ff = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wave(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      rxd_in = 1'b1; repeat (h) @(negedge clk);
      rxd_in = 1'b0; repeat (l) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic expect4(input string req, input int a, input int b, input int c, input int d);
    chk({req, " rise_pass"}, rp, a);
    chk({req, " rise_fail"}, rf, b);
    chk({req, " fall_pass"}, fp, c);
    chk({req, " fall_fail"}, ff, d);
  endtask

  task automatic t_reset_r1;
    do_reset(0);
    wr(0, 8'd20); wr(1, 8'd20);
    do_reset(0);
    chk("R1 strobes idle", int'(rise_pass | rise_fail | fall_pass | fall_fail), 0);
    wave(10, 10, 4);
    expect4("R1 zero limits", 0, 3, 0, 3);
  endtask

  task automatic t_latency_r2_r3;
    do_reset(0);
    wr(0, 8'd18); wr(1, 8'd22);
    rxd_in = 1'b1; repeat (10) @(negedge clk);
    rxd_in = 1'b0; repeat (10) @(negedge clk);
    repeat (10) @(negedge clk);
    expect4("R3 first edges", 0, 0, 0, 0);
    do_reset(0);
    rxd_in = 1'b1; repeat (10) @(negedge clk);
    rxd_in = 1'b0; repeat (10) @(negedge clk);
    rxd_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 not before edge A+2", int'(rise_pass | rise_fail), 0);
    @(negedge clk);
    chk("R2 strobe on edge A+2", int'(rise_pass | rise_fail), 1);
    @(negedge clk);
    chk("R11 strobe one cycle", int'(rise_pass | rise_fail), 0);
    rxd_in = 1'b0; repeat (8) @(negedge clk);
  endtask

  task automatic t_window_r4_r5_r6;
    do_reset(0); wr(0, 8'd18); wr(1, 8'd22);
    wave(10, 10, 5);
    expect4("R4 in window", 4, 0, 4, 0);
    do_reset(0); wr(0, 8'd20); wr(1, 8'd20);
    wave(10, 10, 3);
    expect4("R4 inclusive bounds", 2, 0, 2, 0);
    do_reset(0); wr(0, 8'd21); wr(1, 8'd30);
    wave(10, 10, 3);
    expect4("R5 below lower", 0, 2, 0, 2);
    do_reset(0); wr(0, 8'd10); wr(1, 8'd19);
    wave(10, 10, 3);
    expect4("R6 above upper", 0, 2, 0, 2);
  endtask

  task automatic t_fold_r7;
    do_reset(0); wr(0, 8'd20); wr(1, 8'd20);
    wave(20, 20, 3);
    expect4("R7 40 reads 20", 2, 0, 2, 0);
    do_reset(0); wr(0, 8'd10); wr(1, 8'd10);
    wave(15, 15, 3);
    expect4("R7 30 reads 10", 2, 0, 2, 0);
    do_reset(0); wr(0, 8'd29); wr(1, 8'd29);
    wave(14, 15, 3);
    expect4("R7 29 reads 29", 2, 0, 2, 0);
  endtask

  task automatic t_split_r8;
    do_reset(0); wr(0, 8'd20); wr(1, 8'd20);
    rxd_in = 1'b1; repeat (5) @(negedge clk);
    rxd_in = 1'b0; repeat (15) @(negedge clk);
    rxd_in = 1'b1; repeat (15) @(negedge clk);
    rxd_in = 1'b0; repeat (5) @(negedge clk);
    rxd_in = 1'b1; repeat (5) @(negedge clk);
    rxd_in = 1'b0; repeat (10) @(negedge clk);
    expect4("R8 separate counters", 2, 0, 0, 2);
  endtask

  task automatic t_half_r9;
    do_reset(1); wr(0, 8'd12); wr(1, 8'd12);
    wave(12, 12, 4);
    expect4("R9 halved tick", 3, 0, 3, 0);
    do_reset(0); wr(0, 8'd12); wr(1, 8'd12);
    wave(12, 12, 3);
    expect4("R9 full tick", 0, 2, 0, 2);
  endtask

  task automatic t_reserved_r10;
    do_reset(0); wr(0, 8'hD4); wr(1, 8'hD4);
    wave(10, 10, 3);
    expect4("R10 reserved ignored", 2, 0, 2, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_latency_r2_r3();
    t_window_r4_r5_r6();
    t_fold_r7();
    t_split_r8();
    t_half_r9();
    t_reserved_r10();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule